// File: doc/BRIEF.md
# UART command frame codec

This block sits between a byte-wide serial receiver/transmitter pair and a simple bus-master request port. Received bytes are gathered into fixed nine-byte command frames. When the last byte of a frame lands, the leading command byte is decoded. A write issues a one-cycle write request with an address and a data word. A read issues a one-cycle read request with an address only. Any other command value drops the frame.

On the return path, a 32-bit response word is broken into bytes for the transmitter, most significant byte first. Each byte is offered with a one-cycle enable pulse, and the next byte is offered only after the transmitter reports done. Two kinds of word become responses: read data delivered by the bus side, and, after every write, the write data itself as an echo. A response that arrives while another is still going out is held in one slot and sent when the current one finishes.

Top module: `uart_cmd_codec`

## Requirements
- R1: A frame is exactly nine strobed bytes; the request pulse appears in the cycle right after the clock edge that takes the ninth byte, and never after fewer bytes.
- R2: Command byte 0x01 (frame byte 1) gives a `wr_req` pulse with `req_addr` from bytes 2..5 and `req_wdata` from bytes 6..9, each most significant byte first (02,03,04,05 gives 0x02030405).
- R3: Command byte 0x02 gives an `rd_req` pulse with `req_addr` from bytes 2..5; bytes 6..9 are taken in to complete the frame but leave `req_wdata` at its previous value.
- R4: Any other command byte gives no request, leaves `req_addr` and `req_wdata` unchanged and starts no response.
- R5: `wr_req` and `rd_req` are single-cycle pulses, never high together, and `req_addr`/`req_wdata` hold their values between pulses.
- R6: A `rsp_valid` strobe with `rsp_word`, taken while idle, gives `tx_en` in the next cycle with `tx_byte` = bits 31:24, followed by bits 23:16, 15:8 and 7:0.
- R7: After each write request, the write data is sent back as a four-byte response, most significant byte first.
- R8: `tx_en` is a one-cycle pulse; within a response, the next byte is offered only in the cycle after `tx_done` is seen for the previous one.
- R9: A response word arriving while four bytes are still being sent is held and sent in full after the current word, without loss or interleaving.
- R10: The active-low asynchronous reset clears the byte counter, the frame and request registers and the transmit sequencer; a partial frame before reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_done | input | 1 | Transmitter finished the current byte |
| rsp_valid | input | 1 | One-cycle strobe: read data word to send back |
| rsp_word | input | 32 | Read data word |
| wr_req | output | 1 | Write request pulse |
| rd_req | output | 1 | Read request pulse |
| req_addr | output | 32 | Request address |
| req_wdata | output | 32 | Write data |
| tx_en | output | 1 | Byte-present pulse for the transmitter |
| tx_byte | output | 8 | Byte to transmit |

## Verification
The assertions take for granted that `tx_done` comes only while a byte is in flight, that `rsp_valid` never shares a cycle with a write request pulse, and that no more than one response word waits while another is being sent. The stimulus respects this by modelling the transmitter as a fixed-delay responder that raises done once per offered byte, by issuing read data only after a read frame has settled, and by sending at most two back-to-back response words. Every command value from 0 to 255 is swept with addresses and data computed from it, so both valid commands and all discarded ones are covered.

// File: rtl/uart_cmd_codec.sv
module uart_cmd_codec #(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4,
  parameter logic [7:0] CMD_WRITE = 8'h01,
  parameter logic [7:0] CMD_READ  = 8'h02
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    tx_done,
  input  logic                    rsp_valid,
  input  logic [DATA_BYTES*8-1:0] rsp_word,
  output logic                    wr_req,
  output logic                    rd_req,
  output logic [ADDR_BYTES*8-1:0] req_addr,
  output logic [DATA_BYTES*8-1:0] req_wdata,
  output logic                    tx_en,
  output logic [7:0]              tx_byte
);
  localparam int AW    = ADDR_BYTES * 8;
  localparam int DW    = DATA_BYTES * 8;
  localparam int FRAME = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int CW    = $clog2(FRAME);
  localparam int SW    = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  // frame collection
  logic [CW-1:0]          rx_cnt;
  logic [8*(FRAME-1)-1:0] rx_buf;
  logic [8*FRAME-1:0]     frame;
  logic                   frame_end;
  logic [7:0]             cmd;

  assign frame     = {rx_buf, rx_byte};
  assign frame_end = rx_valid && (rx_cnt == CW'(FRAME - 1));
  assign cmd       = frame[8*FRAME-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt    <= '0;
      rx_buf    <= '0;
      wr_req    <= 1'b0;
      rd_req    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      wr_req <= 1'b0;
      rd_req <= 1'b0;
      if (rx_valid) begin
        rx_buf <= frame[8*(FRAME-1)-1:0];
        rx_cnt <= frame_end ? '0 : rx_cnt + 1'b1;
      end
      if (frame_end) begin
        if (cmd == CMD_WRITE) begin
          wr_req    <= 1'b1;
          req_addr  <= frame[DW +: AW];
          req_wdata <= frame[DW-1:0];
        end else if (cmd == CMD_READ) begin
          rd_req   <= 1'b1;
          req_addr <= frame[DW +: AW];
        end
      end
    end
  end

  // response serialiser
  logic          busy, hold_v, in_v;
  logic [SW-1:0] tx_idx;
  logic [DW-1:0] tx_sh, hold_w, in_w;

  assign in_v    = rsp_valid | wr_req;
  assign in_w    = rsp_valid ? rsp_word : req_wdata;
  assign tx_byte = tx_sh[DW-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tx_en  <= 1'b0;
      tx_idx <= '0;
      tx_sh  <= '0;
      hold_v <= 1'b0;
      hold_w <= '0;
    end else begin
      tx_en <= 1'b0;
      if (!busy) begin
        if (hold_v || in_v) begin
          busy   <= 1'b1;
          tx_en  <= 1'b1;
          tx_idx <= '0;
          tx_sh  <= hold_v ? hold_w : in_w;
          hold_v <= hold_v && in_v;
          if (hold_v && in_v) hold_w <= in_w;
        end
      end else begin
        if (in_v) begin
          hold_v <= 1'b1;
          hold_w <= in_w;
        end
        if (tx_done) begin
          if (tx_idx == SW'(DATA_BYTES - 1)) begin
            busy <= 1'b0;
          end else begin
            tx_idx <= tx_idx + 1'b1;
            tx_sh  <= tx_sh << 8;
            tx_en  <= 1'b1;
          end
        end
      end
    end
  end

  a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_req, rd_req}));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |=> !(wr_req || rd_req));

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req || rd_req) |-> $stable(req_addr) && $stable(req_wdata));

  a_r8_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done) |=> !tx_en);

  a_r8_en_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> !tx_en);

  a_r1_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !(wr_req || rd_req));

endmodule

// File: tb/tb_uart_cmd_codec.sv
`timescale 1ns/1ps
module tb_uart_cmd_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_done = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_word = '0;
  logic        wr_req, rd_req, tx_en;
  logic [31:0] req_addr, req_wdata;
  logic [7:0]  tx_byte;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  int tx_n = 0, cd = 0, seq_viol = 0;
  bit done_seen = 0;
  logic [7:0] tx_log [0:15];

  always #2.5 clk = ~clk;

  uart_cmd_codec dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_done(tx_done), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .wr_req(wr_req), .rd_req(rd_req), .req_addr(req_addr),
    .req_wdata(req_wdata), .tx_en(tx_en), .tx_byte(tx_byte)
  );

  // transmitter model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (wr_req) wr_cnt++;
    if (rd_req) rd_cnt++;
    tx_done = 1'b0;
    if (!rst_n) begin
      cd = 0;
    end else if (tx_en) begin
      if ((tx_n % 4) != 0 && !done_seen) seq_viol++;
      if (tx_n < 16) tx_log[tx_n] = tx_byte;
      tx_n++;
      done_seen = 0;
      cd = 3;
    end else if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        tx_done = 1'b1;
        done_seen = 1;
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic put_frame(input logic [7:0] c, input logic [31:0] a, input logic [31:0] d,
                           output bit wr_seen, output bit rd_seen);
    put_byte(c);
    for (int i = 3; i >= 0; i--) put_byte(a[8*i +: 8]);
    for (int i = 3; i >= 1; i--) put_byte(d[8*i +: 8]);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = d[7:0];
    @(negedge clk);
    rx_valid = 1'b0;
    wr_seen = wr_req;
    rd_seen = rd_req;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_word(input int base, input logic [31:0] w, input string req);
    for (int k = 0; k < 4; k++)
      check(tx_log[base + k] === w[31 - 8*k -: 8], req, tx_log[base + k], w[31 - 8*k -: 8]);
  endtask

  initial begin
    bit ws, rs;
    logic [31:0] exp_a, exp_d, a, d, w;
    int wc, rc;

    #12 rst_n = 1'b1;
    @(negedge clk);
    check(!wr_req && !rd_req && !tx_en, "R10 reset outputs", {wr_req, rd_req, tx_en}, 0);
    check(req_addr === 0 && req_wdata === 0, "R10 reset regs", {req_addr, req_wdata}, 0);
    exp_a = 0;
    exp_d = 0;

    // R1: eight bytes make no request
    wc = wr_cnt;
    put_byte(8'h01);
    for (int i = 0; i < 7; i++) put_byte(8'h10 + 8'(i));
    wait_cycles(3);
    check(wr_cnt == wc && rd_cnt == 0, "R1 partial frame", wr_cnt, wc);
    // R10: reset mid-frame forgets the partial frame
    rst_n = 1'b0;
    #1 rst_n = 1'b1;
    @(negedge clk);
    put_frame(8'h01, 32'h02030405, 32'h06070809, ws, rs);
    check(ws && !rs, "R1 request after ninth byte", {ws, rs}, 2'b10);
    check(req_addr === 32'h02030405, "R2 address", req_addr, 32'h02030405);
    check(req_wdata === 32'h06070809, "R2 data", req_wdata, 32'h06070809);
    exp_a = 32'h02030405;
    exp_d = 32'h06070809;
    tx_n = 0;
    wait_cycles(40);
    check(tx_n == 4, "R7 echo length", tx_n, 4);
    check_word(0, 32'h06070809, "R7 echo bytes");

    // sweep over every command value
    for (int c = 0; c < 256; c++) begin
      a  = 32'h9E3779B9 * (c + 1);
      d  = (32'h85EBCA6B * (c + 7)) ^ 32'h00FF00FF;
      w  = a ^ d ^ 32'hA5A5_0000;
      wc = wr_cnt;
      rc = rd_cnt;
      tx_n = 0;
      put_frame(8'(c), a, d, ws, rs);
      if (c == 1) begin
        exp_a = a;
        exp_d = d;
        check(ws && !rs, "R2 write pulse", {ws, rs}, 2'b10);
      end else if (c == 2) begin
        exp_a = a;
        check(rs && !ws, "R3 read pulse", {ws, rs}, 2'b01);
      end else begin
        check(!ws && !rs, "R4 no request", {ws, rs}, 0);
      end
      wait_cycles(40);
      check(req_addr === exp_a, "R2 R3 R4 address", req_addr, exp_a);
      check(req_wdata === exp_d, "R3 R4 write data kept", req_wdata, exp_d);
      check(wr_cnt == wc + (c == 1 ? 1 : 0) && rd_cnt == rc + (c == 2 ? 1 : 0),
            "R5 one pulse per frame", {wr_cnt, rd_cnt}, {wc, rc});
      if (c == 1) begin
        check(tx_n == 4, "R7 echo length", tx_n, 4);
        check_word(0, d, "R7 echo bytes");
      end else begin
        check(tx_n == 0, "R4 R3 no response", tx_n, 0);
      end
      if (c == 2) begin
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_word  = w;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(tx_en && tx_byte === w[31:24], "R6 first byte timing", {tx_en, tx_byte}, {1'b1, w[31:24]});
        wait_cycles(40);
        check(tx_n == 4, "R6 response length", tx_n, 4);
        check_word(0, w, "R6 response bytes");
      end
    end

    // R9: second word arrives while the first is being sent
    tx_n = 0;
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_word  = 32'hCAFE_F00D;
    @(negedge clk);
    rsp_word  = 32'h1234_5678;
    @(negedge clk);
    rsp_valid = 1'b0;
    wait_cycles(80);
    check(tx_n == 8, "R9 both words sent", tx_n, 8);
    check_word(0, 32'hCAFE_F00D, "R9 first word");
    check_word(4, 32'h1234_5678, "R9 held word");

    check(seq_viol == 0, "R8 byte only after done", seq_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule